// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned words and reports whether the first is greater than, equal to, or less than the second. It is built from identical 4-bit slices. Each slice works out the result for its own nibble pair. It also takes three relation inputs from the slice below it, which settle the answer when its own nibbles tie. The whole path is combinational.

The top level chains a parameter-chosen number of slices, from the least significant nibble upwards. Each slice's three outputs feed the relation inputs of the next slice up. The final verdict comes from the most significant slice. The top keeps its own three relation inputs, so a complete comparator can itself sit above another one. For a standalone compare, those inputs are driven as greater=0, equal=1, less=0.

Top module: `cmp_chain`

## Requirements
- R1: A slice treats its nibble pair as equal only when every bit position matches (the AND of per-bit XNORs). Any single-bit difference, at any position 0..3, breaks the tie.
- R2: When a slice's nibbles differ, its outputs show the local unsigned result: {gt,eq,lt} = 100 if A>B and 001 if A<B. The relation inputs have no effect in this case.
- R3: When a slice's nibbles are equal, its three outputs copy its three relation inputs bit for bit, including patterns that are not one-hot.
- R4: Whenever the relation inputs are one-hot, exactly one of gt_o, eq_o, lt_o is high.
- R5: With relation inputs greater=0, equal=1, less=0, the outputs match unsigned A>B, A==B and A<B over the full word width.
- R6: A difference in a more significant nibble decides the result regardless of any difference in a less significant nibble.
- R7: The word width is 4 × NUM_SLICES bits, with bit 0 as the LSB. The same RTL gives correct results for 2 slices (8 bits) and 4 slices (16 bits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*NUM_SLICES | First unsigned operand, bit 0 is LSB |
| b_i | input | 4*NUM_SLICES | Second unsigned operand, bit 0 is LSB |
| cas_gt_i | input | 1 | Lower-order result: A greater |
| cas_eq_i | input | 1 | Lower-order result: equal (tie high when standalone) |
| cas_lt_i | input | 1 | Lower-order result: A less |
| gt_o | output | 1 | A is greater than B |
| eq_o | output | 1 | A equals B |
| lt_o | output | 1 | A is less than B |

## Verification
The hardest case to reach from the ports is a full-width tie. Only then does every slice pass its relation inputs straight through. Random 16-bit operands almost never produce one, and they almost never produce ties confined to the upper nibbles either. The stimulus therefore copies A into B, then flips only chosen low nibbles, or none. This reaches both full ties and upper-nibble ties with a low-order decision. Full ties are also driven with non-one-hot relation patterns, so the pass-through behaviour is visible. The 8-bit instance is swept exhaustively, so it covers every tie pattern.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    localparam int SLICE_W = 4;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } rel_t;

    localparam rel_t REL_GT = '{gt: 1'b1, eq: 1'b0, lt: 1'b0};
    localparam rel_t REL_LT = '{gt: 1'b0, eq: 1'b0, lt: 1'b1};
endpackage

// File: rtl/cmp_nib_eq.sv
module cmp_nib_eq
    import cmp_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         eq_o
);
    logic [W-1:0] match_d;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign match_d[i] = ~(a_i[i] ^ b_i[i]);
        end
    endgenerate

    assign eq_o = &match_d;
endmodule

// File: rtl/cmp_nib_mag.sv
module cmp_nib_mag
    import cmp_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         gt_o
);
    logic gt_d;
    logic done_d;

    // Scan from MSB down; the first differing bit decides.
    always_comb begin
        gt_d   = 1'b0;
        done_d = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!done_d && (a_i[i] != b_i[i])) begin
                gt_d   = a_i[i];
                done_d = 1'b1;
            end
        end
    end

    assign gt_o = gt_d;
endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
    import cmp_pkg::*;
(
    input  logic [SLICE_W-1:0] a_i,
    input  logic [SLICE_W-1:0] b_i,
    input  rel_t               cas_i,
    output rel_t               rel_o
);
    logic nib_eq;
    logic nib_gt;
    rel_t rel_d;

    cmp_nib_eq #(.W(SLICE_W)) u_eq (
        .a_i  (a_i),
        .b_i  (b_i),
        .eq_o (nib_eq)
    );

    cmp_nib_mag #(.W(SLICE_W)) u_mag (
        .a_i  (a_i),
        .b_i  (b_i),
        .gt_o (nib_gt)
    );

    always_comb begin
        if (nib_eq) begin
            rel_d = cas_i;
        end else if (nib_gt) begin
            rel_d = REL_GT;
        end else begin
            rel_d = REL_LT;
        end
    end

    assign rel_o = rel_d;
endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
    import cmp_pkg::*;
#(
    parameter int NUM_SLICES = 4,
    localparam int WORD_W = SLICE_W * NUM_SLICES
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic              cas_gt_i,
    input  logic              cas_eq_i,
    input  logic              cas_lt_i,
    output logic              gt_o,
    output logic              eq_o,
    output logic              lt_o
);
    rel_t link_d [NUM_SLICES+1];

    assign link_d[0] = '{gt: cas_gt_i, eq: cas_eq_i, lt: cas_lt_i};

    generate
        for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
            cmp_slice u_slice (
                .a_i   (a_i[s*SLICE_W +: SLICE_W]),
                .b_i   (b_i[s*SLICE_W +: SLICE_W]),
                .cas_i (link_d[s]),
                .rel_o (link_d[s+1])
            );
        end
    endgenerate

    assign gt_o = link_d[NUM_SLICES].gt;
    assign eq_o = link_d[NUM_SLICES].eq;
    assign lt_o = link_d[NUM_SLICES].lt;
endmodule

// File: rtl/cmp_chain_chk.sv
module cmp_chain_chk #(
    parameter int NUM_SLICES = 4,
    localparam int WORD_W = 4 * NUM_SLICES
) (
    input logic [WORD_W-1:0] a_i,
    input logic [WORD_W-1:0] b_i,
    input logic              cas_gt_i,
    input logic              cas_eq_i,
    input logic              cas_lt_i,
    input logic              gt_o,
    input logic              eq_o,
    input logic              lt_o
);
    always_comb begin
        // R4
        onehot_out_chk: assert (!$onehot({cas_gt_i, cas_eq_i, cas_lt_i})
                                || $onehot({gt_o, eq_o, lt_o}));
        // R3
        tie_pass_chk: assert ((a_i != b_i)
                              || ({gt_o, eq_o, lt_o} == {cas_gt_i, cas_eq_i, cas_lt_i}));
        // R2
        local_win_chk: assert ((a_i == b_i)
                               || ({gt_o, eq_o, lt_o} == {a_i > b_i, 1'b0, a_i < b_i}));
        // R5
        native_match_chk: assert (!(cas_eq_i && !cas_gt_i && !cas_lt_i)
                                  || ({gt_o, eq_o, lt_o} == {a_i > b_i, a_i == b_i, a_i < b_i}));
    end
endmodule

bind cmp_chain cmp_chain_chk #(.NUM_SLICES(NUM_SLICES)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .cas_gt_i (cas_gt_i),
    .cas_eq_i (cas_eq_i),
    .cas_lt_i (cas_lt_i),
    .gt_o     (gt_o),
    .eq_o     (eq_o),
    .lt_o     (lt_o)
);

// File: tb/tb_cmp_chain.sv
module tb_cmp_chain;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [15:0] a16, b16;
    logic [7:0]  a8, b8;
    logic [2:0]  cas16, cas8;
    logic        gt16, eq16, lt16, gt8, eq8, lt8;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    cmp_chain #(.NUM_SLICES(4)) dut (
        .a_i(a16), .b_i(b16),
        .cas_gt_i(cas16[2]), .cas_eq_i(cas16[1]), .cas_lt_i(cas16[0]),
        .gt_o(gt16), .eq_o(eq16), .lt_o(lt16)
    );

    cmp_chain #(.NUM_SLICES(2)) dut8 (
        .a_i(a8), .b_i(b8),
        .cas_gt_i(cas8[2]), .cas_eq_i(cas8[1]), .cas_lt_i(cas8[0]),
        .gt_o(gt8), .eq_o(eq8), .lt_o(lt8)
    );

    function automatic logic [2:0] exp_rel(input logic [15:0] a, input logic [15:0] b,
                                           input logic [2:0] cas);
        if (a > b)      return 3'b100;
        else if (a < b) return 3'b001;
        else            return cas;
    endfunction

    task automatic run16(input logic [15:0] a, input logic [15:0] b,
                         input logic [2:0] cas, input string tag);
        logic [2:0] exp;
        @(posedge clk); #1;
        a16 = a; b16 = b; cas16 = cas;
        #1;
        exp = exp_rel(a, b, cas);
        n_chk++;
        if ({gt16, eq16, lt16} !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h cas=%b actual=%b expected=%b",
                     tag, a, b, cas, {gt16, eq16, lt16}, exp);
        end
    endtask

    task automatic run8(input logic [7:0] a, input logic [7:0] b,
                        input logic [2:0] cas, input string tag);
        logic [2:0] exp;
        @(posedge clk); #1;
        a8 = a; b8 = b; cas8 = cas;
        #1;
        exp = exp_rel({8'h0, a}, {8'h0, b}, cas);
        n_chk++;
        if ({gt8, eq8, lt8} !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h cas=%b actual=%b expected=%b",
                     tag, a, b, cas, {gt8, eq8, lt8}, exp);
        end
    endtask

    initial begin
        a16 = '0; b16 = '0; cas16 = 3'b010;
        a8 = '0; b8 = '0; cas8 = 3'b010;
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R5: idle/reset state, zero operands read as equal
        run16(16'h0000, 16'h0000, 3'b010, "R5 reset-state");

        // R1: single-bit differences at each position of low slice
        for (int i = 0; i < 4; i++) begin
            run16(16'h0000, 16'h0001 << i, 3'b010, "R1 bit-diff lt");
            run16(16'hA5A0 | (16'h1 << i), 16'hA5A0, 3'b010, "R1 bit-diff gt");
        end

        // R2: local difference overrides odd cascade patterns
        for (int c = 0; c < 8; c++) begin
            run16(16'h1234, 16'h1235, 3'(c), "R2 local-lt wins");
            run16(16'h9000, 16'h8FFF, 3'(c), "R2 local-gt wins");
        end

        // R3: full tie copies every cascade pattern, including non-one-hot
        for (int c = 0; c < 8; c++)
            run16(16'hBEEF, 16'hBEEF, 3'(c), "R3 tie-pass");

        // R6: upper nibble decides over opposite lower difference
        run16(16'h2000, 16'h1FFF, 3'b010, "R6 msb-dominates gt");
        run16(16'h0FFF, 16'h1000, 3'b010, "R6 msb-dominates lt");
        run16(16'h5F00, 16'h50FF, 3'b010, "R6 mid-nibble");

        // R4/R5: random, with ties confined to upper nibbles
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] ra, rb;
            logic [2:0]  rc;
            ra = 16'($urandom);
            case (k % 4)
                0: rb = 16'($urandom);
                1: rb = ra;
                2: rb = ra ^ 16'($urandom & 32'h000F);
                default: rb = ra ^ 16'($urandom & 32'h00FF);
            endcase
            rc = (k % 3 == 0) ? 3'b100 : ((k % 3 == 1) ? 3'b001 : 3'b010);
            run16(ra, rb, rc, "R4 R5 random16");
        end

        // R7: exhaustive 8-bit instance
        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y++)
                run8(8'(x), 8'(y), 3'b010, "R7 exhaustive8");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule